// File: doc/BRIEF.md
# I2S Audio Receive Path with Sample FIFO

This block captures stereo audio from a serial codec link and queues it for a processor or DMA engine. It watches the bit clock, word select and serial data lines and oversamples them on the system clock. It assembles 16-bit samples, MSB first, and tags each one as left or right. Each completed sample goes into a 16-entry FIFO. The read side sees the oldest sample on its data output and removes it with a one-cycle read strobe. A DMA request is raised once the number of stored samples reaches a programmable threshold.

Two controls stop capture. When the unit enable is cleared, or record-disable is set, the serial shifter and the FIFO pointers and level are flushed. While record is disabled, reads return zero and DMA requests are held low. A sample that arrives while the FIFO is full is discarded, and the data already stored is kept. The discard sets a sticky overrun flag, and that flag can drive an interrupt.

Top module: `i2s_rx_top`

## Requirements
- R1: A sample is the 16 bits of `sd_i` taken on successive rising edges of `sck_i`, MSB first. The MSB is on the first rising edge after the one where `ws_i` is seen to change. The sample is complete at the next `ws_i` change, and `rd_right_o` stores the `ws_i` level during its bits (0 = left, 1 = right).
- R2: After capture starts, and after every restart, nothing is stored until the first `ws_i` change has been seen. The word in progress at that change is discarded.
- R3: Samples are read in arrival order, up to 16 of them, and `level_o` gives the number stored.
- R4: A sample that completes while 16 are stored (with no read in that cycle) is discarded. The stored samples are unchanged and `ovr_o` is set.
- R5: `ovr_o` stays set until a cycle with `ovr_clr_i` high. A new overrun in that same cycle keeps it set.
- R6: `irq_o` is high exactly when `ovr_o` and `ovr_ie_i` are both high.
- R7: With capture active, `dma_req_o` is high one cycle after `level_o` is at or above `thresh_i`, and low one cycle after `level_o` falls below it.
- R8: Raising `rec_dis_i` sets `level_o` to 0 and resets both pointers. A partly received sample is lost, and samples that arrive while it is high are not stored.
- R9: While `rec_dis_i` is high, `rd_data_o` and `rd_right_o` read zero and `rd_i` removes nothing.
- R10: While `rec_dis_i` is high, `dma_req_o` is low.
- R11: Clearing `en_i` flushes the FIFO and the shifter in the same way as R8.
- R12: A codec sending all-zero data produces a continuous run of zero samples for as long as capture stays enabled.
- R13: A read of an empty FIFO returns zero and leaves `level_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, used to oversample the serial lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Unit enable |
| rec_dis_i | input | 1 | Record-disable |
| sck_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Word select, 0 = left channel |
| sd_i | input | 1 | Serial data |
| rd_i | input | 1 | Read strobe; removes the head sample |
| rd_data_o | output | 16 | Head sample data |
| rd_right_o | output | 1 | Head sample channel flag |
| level_o | output | 5 | Number of stored samples |
| thresh_i | input | 5 | DMA request threshold |
| dma_req_o | output | 1 | DMA request |
| ovr_ie_i | input | 1 | Overrun interrupt enable |
| ovr_clr_i | input | 1 | Clear strobe for the overrun flag |
| ovr_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Overrun interrupt |

## Verification
The assertions check these rules on every cycle: the level returns to zero after a flush, a full FIFO keeps its level when a sample is dropped, the overrun flag is sticky and is set by a dropped sample, the DMA request follows the threshold and stays masked while record is off, and reads give zero while record is off. Some behaviour only the bench scenarios can show, because it needs a reference model of the data. That covers the bit order and channel tags of captured samples and the discard of the first partial word. It also covers which samples survive an overrun, the loss of a half-received word on record-disable, and the zero samples recorded from a silent codec.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
  localparam int SAMPLE_W = 16;

  typedef struct packed {
    logic                right;
    logic [SAMPLE_W-1:0] data;
  } rx_sample_t;
endpackage

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
  import i2s_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       sck_i,
  input  logic       ws_i,
  input  logic       sd_i,
  output logic       smp_valid_o,
  output rx_sample_t smp_o
);
  localparam int CNT_W = $clog2(SAMPLE_W + 1);

  logic                sck_q, primed_q, synced_q, ws_q;
  logic [SAMPLE_W-1:0] shreg_q, shreg_nxt;
  logic [CNT_W-1:0]    cnt_q, cnt_nxt, pad;
  logic                rise, take, ws_edge;

  assign rise    = sck_i & ~sck_q;
  assign ws_edge = primed_q & (ws_i != ws_q);

  always_comb begin
    take      = cnt_q < CNT_W'(SAMPLE_W);
    shreg_nxt = take ? {shreg_q[SAMPLE_W-2:0], sd_i} : shreg_q;
    cnt_nxt   = take ? cnt_q + 1'b1 : cnt_q;
    pad       = CNT_W'(SAMPLE_W) - cnt_nxt;   // MSB-align short words
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q       <= 1'b0;
      primed_q    <= 1'b0;
      synced_q    <= 1'b0;
      ws_q        <= 1'b0;
      shreg_q     <= '0;
      cnt_q       <= '0;
      smp_valid_o <= 1'b0;
      smp_o       <= '0;
    end else begin
      sck_q       <= sck_i;
      smp_valid_o <= 1'b0;
      if (!active_i) begin
        primed_q <= 1'b0;
        synced_q <= 1'b0;
        shreg_q  <= '0;
        cnt_q    <= '0;
      end else if (rise) begin
        primed_q <= 1'b1;
        ws_q     <= ws_i;
        if (ws_edge) begin
          synced_q <= 1'b1;
          shreg_q  <= '0;
          cnt_q    <= '0;
          if (synced_q) begin
            smp_valid_o <= 1'b1;
            smp_o.data  <= shreg_nxt << pad;
            smp_o.right <= ws_q;
          end
        end else begin
          shreg_q <= shreg_nxt;
          cnt_q   <= cnt_nxt;
        end
      end
    end
  end

  // at most one sample per bit clock edge
  assert_single_sample_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |=> !smp_valid_o);

  assert_stop_when_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !smp_valid_o);
endmodule

// File: rtl/i2s_rx_fifo.sv
module i2s_rx_fifo
  import i2s_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          wr_i,
  input  rx_sample_t    wr_data_i,
  input  logic          rd_i,
  output rx_sample_t    rd_data_o,
  output logic [CW-1:0] level_o,
  output logic          ovr_o
);
  rx_sample_t    mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          full, empty, rd_fire, wr_fire;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = cnt_q == CW'(DEPTH);
  assign empty   = cnt_q == '0;
  assign rd_fire = rd_i & ~empty & ~flush_i;
  assign wr_fire = wr_i & ~flush_i & (~full | rd_fire);
  assign ovr_o   = wr_i & ~flush_i & full & ~rd_fire;

  assign rd_data_o = empty ? '0 : mem[rptr_q];
  assign level_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (wr_fire) mem[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_fire) wptr_q <= ptr_inc(wptr_q);
      if (rd_fire) rptr_q <= ptr_inc(rptr_q);
      case ({wr_fire, rd_fire})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_flush_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (level_o == '0));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> (level_o == CW'(DEPTH)) && $stable(wptr_q));

  assert_level_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CW'(DEPTH));
endmodule

// File: rtl/i2s_rx_ctrl.sv
module i2s_rx_ctrl #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic [CW-1:0] level_i,
  input  logic [CW-1:0] thresh_i,
  input  logic          ovr_evt_i,
  input  logic          ovr_clr_i,
  input  logic          ovr_ie_i,
  output logic          dma_req_o,
  output logic          ovr_o,
  output logic          irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_req_o <= 1'b0;
      ovr_o     <= 1'b0;
    end else begin
      dma_req_o <= active_i & (level_i >= thresh_i);
      if (ovr_evt_i)      ovr_o <= 1'b1;   // set wins over clear
      else if (ovr_clr_i) ovr_o <= 1'b0;
    end
  end

  assign irq_o = ovr_o & ovr_ie_i;

  assert_req_masked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !dma_req_o);

  assert_req_on_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && (level_i >= thresh_i)) |=> dma_req_o);

  assert_ovr_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_clr_i) |=> ovr_o);

  assert_ovr_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_evt_i |=> ovr_o);
endmodule

// File: rtl/i2s_rx_top.sv
module i2s_rx_top
  import i2s_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                rec_dis_i,
  input  logic                sck_i,
  input  logic                ws_i,
  input  logic                sd_i,
  input  logic                rd_i,
  output logic [SAMPLE_W-1:0] rd_data_o,
  output logic                rd_right_o,
  output logic [CW-1:0]       level_o,
  input  logic [CW-1:0]       thresh_i,
  output logic                dma_req_o,
  input  logic                ovr_ie_i,
  input  logic                ovr_clr_i,
  output logic                ovr_o,
  output logic                irq_o
);
  logic       active, smp_valid, ovr_evt;
  rx_sample_t smp, head;

  assign active = en_i & ~rec_dis_i;

  i2s_rx_deser u_deser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .sck_i       (sck_i),
    .ws_i        (ws_i),
    .sd_i        (sd_i),
    .smp_valid_o (smp_valid),
    .smp_o       (smp)
  );

  i2s_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (~active),
    .wr_i      (smp_valid),
    .wr_data_i (smp),
    .rd_i      (rd_i & active),
    .rd_data_o (head),
    .level_o   (level_o),
    .ovr_o     (ovr_evt)
  );

  i2s_rx_ctrl #(.CW(CW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .level_i   (level_o),
    .thresh_i  (thresh_i),
    .ovr_evt_i (ovr_evt),
    .ovr_clr_i (ovr_clr_i),
    .ovr_ie_i  (ovr_ie_i),
    .dma_req_o (dma_req_o),
    .ovr_o     (ovr_o),
    .irq_o     (irq_o)
  );

  assign rd_data_o  = active ? head.data  : '0;
  assign rd_right_o = active ? head.right : 1'b0;

  assert_read_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_dis_i |-> (rd_data_o == '0) && !rd_right_o);

  assert_flush_on_disable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (level_o == '0) && !dma_req_o);
endmodule

// File: tb/i2s_rx_top_bench.sv
module i2s_rx_top_bench;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        en = 1'b0, rec_dis = 1'b0, sck = 1'b0, ws = 1'b1, sd = 1'b0;
  logic        rd = 1'b0, ovr_ie = 1'b0, ovr_clr = 1'b0;
  logic [4:0]  thresh = 5'd4;
  logic [15:0] rd_data;
  logic        rd_right, dma_req, ovr, irq;
  logic [4:0]  level;

  int n_chk = 0, n_fail = 0;
  int unsigned seed = 32'h1234_5678;

  // reference queue
  logic [15:0] m_data [256];
  logic        m_right [256];
  int m_head = 0, m_tail = 0, m_cnt = 0;
  logic        next_right = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  i2s_rx_top u_i2s_rx_top (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .rec_dis_i(rec_dis),
    .sck_i(sck), .ws_i(ws), .sd_i(sd), .rd_i(rd),
    .rd_data_o(rd_data), .rd_right_o(rd_right), .level_o(level),
    .thresh_i(thresh), .dma_req_o(dma_req), .ovr_ie_i(ovr_ie),
    .ovr_clr_i(ovr_clr), .ovr_o(ovr), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_req(input int lvl, input int th, input bit act);
    return act && (lvl >= th);
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_slot(input logic b, input logic w);
    @(negedge clk); sck = 1'b0; sd = b; ws = w;
    @(negedge clk);
    @(negedge clk); sck = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] d, input logic right, input int nbits);
    for (int b = 15; b >= 16 - nbits; b--)
      bit_slot(d[b], (b == 0) ? ~right : right);
  endtask

  // stream a sample and update the model
  task automatic push(input logic [15:0] d);
    send_word(d, next_right, 16);
    if (m_cnt < DEPTH) begin
      m_data[m_tail % 256]  = d;
      m_right[m_tail % 256] = next_right;
      m_tail++; m_cnt++;
    end
    next_right = ~next_right;
  endtask

  task automatic preamble();
    send_word(16'h0, 1'b1, 16);
    next_right = 1'b0;
  endtask

  task automatic read_chk(input string tag);
    @(negedge clk);
    chk({tag, " data"}, int'(rd_data), int'(m_data[m_head % 256]));
    chk({tag, " chan"}, int'(rd_right), int'(m_right[m_head % 256]));
    rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    m_head++; m_cnt--;
  endtask

  task automatic drain(input string tag);
    while (m_cnt > 0) read_chk(tag);
    wait_cyc(2);
    chk({tag, " level empty"}, int'(level), 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] w;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    // reset state
    chk("R3 reset level", int'(level), 0);
    chk("R7 reset dma", int'(dma_req), 0);
    chk("R5 reset ovr", int'(ovr), 0);
    chk("R6 reset irq", int'(irq), 0);

    en = 1'b1;
    wait_cyc(2);
    // R2: first word discarded, only post-transition words kept
    send_word(16'hDEAD, 1'b1, 16);
    next_right = 1'b0;
    wait_cyc(4);
    chk("R2 sync word dropped", int'(level), 0);

    // R1/R3/R7 threshold 4
    thresh = 5'd4;
    push(16'h8001); push(16'h7FFE); push(16'hA5C3);
    wait_cyc(4);
    chk("R3 level 3", int'(level), 3);
    chk("R7 below thresh", int'(dma_req), int'(exp_req(3, 4, 1)));
    push(16'h0F0F);
    wait_cyc(4);
    chk("R3 level 4", int'(level), 4);
    chk("R7 at thresh", int'(dma_req), int'(exp_req(4, 4, 1)));
    drain("R1 order");
    chk("R7 req drop", int'(dma_req), int'(exp_req(0, 4, 1)));

    // R13 empty read
    @(negedge clk);
    chk("R13 empty data", int'(rd_data), 0);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    wait_cyc(1);
    chk("R13 empty level", int'(level), 0);

    // R4 overrun: 18 samples into 16 slots
    for (int i = 0; i < 18; i++) push(16'($urandom(seed)));
    wait_cyc(4);
    chk("R4 full level", int'(level), 16);
    chk("R4 ovr set", int'(ovr), 1);
    chk("R6 irq masked", int'(irq), 0);
    ovr_ie = 1'b1; wait_cyc(1);
    chk("R6 irq on", int'(irq), 1);
    drain("R4 kept data");
    chk("R5 still set", int'(ovr), 1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    wait_cyc(1);
    chk("R5 cleared", int'(ovr), 0);
    chk("R6 irq off", int'(irq), 0);
    ovr_ie = 1'b0;

    // R8/R9/R10 record-disable with a partial word
    for (int i = 0; i < 5; i++) push(16'($urandom(seed)));
    send_word(16'hFFFF, next_right, 8);
    wait_cyc(2);
    chk("R7 dma before disable", int'(dma_req), 1);
    rec_dis = 1'b1;
    wait_cyc(2);
    chk("R8 level flushed", int'(level), 0);
    chk("R10 dma masked", int'(dma_req), 0);
    chk("R9 read zero", int'(rd_data), 0);
    chk("R9 chan zero", int'(rd_right), 0);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    send_word(16'h1234, 1'b0, 16);
    send_word(16'h5678, 1'b1, 16);
    wait_cyc(4);
    chk("R8 nothing stored", int'(level), 0);
    chk("R10 dma still low", int'(dma_req), 0);
    m_head = 0; m_tail = 0; m_cnt = 0;
    rec_dis = 1'b0;
    wait_cyc(2);
    chk("R8 level after release", int'(level), 0);
    preamble();
    push(16'hC0DE); push(16'h4321);
    wait_cyc(4);
    chk("R8 fresh level", int'(level), 2);
    drain("R8 fresh data");

    // R11 unit enable flush
    push(16'h1111); push(16'h2222); push(16'h3333);
    wait_cyc(4);
    chk("R11 pre level", int'(level), 3);
    en = 1'b0;
    wait_cyc(2);
    chk("R11 flushed", int'(level), 0);
    m_head = 0; m_tail = 0; m_cnt = 0;
    en = 1'b1;
    wait_cyc(2);

    // R12 silent codec
    preamble();
    for (int i = 0; i < 6; i++) push(16'h0000);
    wait_cyc(4);
    chk("R12 zero count", int'(level), 6);
    drain("R12 zero data");

    // random rounds
    for (int r = 0; r < 8; r++) begin
      int n;
      n = 1 + int'($urandom(seed) % 12);
      thresh = 5'(1 + ($urandom(seed) % 16));
      for (int i = 0; i < n; i++) begin
        w = 16'($urandom(seed));
        push(w);
      end
      wait_cyc(4);
      chk("R3 rand level", int'(level), m_cnt);
      chk("R7 rand dma", int'(dma_req), int'(exp_req(m_cnt, int'(thresh), 1)));
      drain("R1 rand data");
    end

    finish_run();
  end
endmodule